// File: doc/BRIEF.md
# Nested Stimulation Pulse Sequencer

This block is the timing engine of one stimulation channel. After a start strobe it waits out a therapy delay and then emits biphasic periods. Each period is a sink pulse, a dead zone, a recharge (source) pulse and a second dead zone. Periods are grouped into sets, sets into master pulses, and a fixed number of master pulses makes one therapy. When the therapy is over the engine falls back to idle. Each gap between periods, sets and master pulses has its own length, counted in its own fixed multiple of the stimulation tick. The recharge pulse is derived from the sink width with a signed trim.

All timing advances only on cycles where the `tick` enable is high. The enable marks the edges of a slow stimulation clock that runs inside the fast system clock. The engine drives a sink enable, a source enable and an 8-bit amplitude code toward the current DACs outside the block. It also drives a busy flag that a host can poll to find the end of a therapy. In ramp mode, the first sets of every master pulse climb toward the programmed amplitude. The configuration inputs must stay stable while `busy` is high.

Top module: `stim_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the engine becomes idle after that edge, with `busy`, `sink_en` and `src_en` low and `amp_code` zero.
- R2: A `trig` pulse sampled while idle raises `busy` in the next cycle. A therapy delay of `cfg_thp`×THP_UNIT ticks then passes before the first sink pulse, and a zero field counts as one tick.
- R3: Each period is a sink pulse of `cfg_pw` ticks, then `cfg_dz0` dead ticks, then the recharge pulse, then `cfg_dz0` dead ticks again. Both zero fields count as one tick.
- R4: The recharge pulse lasts 4×(sink width) ticks, adjusted by `cfg_delta[6:0]`. The adjustment is added when `cfg_delta[7]`=0 and subtracted when `cfg_delta[7]`=1, and the result never drops below one tick.
- R5: Consecutive periods inside a set are separated by `cfg_dz1`×DZ1_UNIT ticks (zero counts as one tick), and a set holds `cfg_m` periods (zero counts as one).
- R6: Consecutive sets inside a master pulse are separated by `cfg_dz2`×DZ2_UNIT ticks (zero counts as one tick), and a master pulse holds `cfg_n` sets (zero counts as one).
- R7: Master pulses are separated by `cfg_dz3`×DZ3_UNIT ticks (zero counts as one tick). After `cfg_p` master pulses (zero counts as one), `busy` falls right after the last trailing dead zone.
- R8: With `cfg_ramp`=1, sets 0, 1 and 2 of every master pulse use `amp>>2`, `amp>>1` and `(amp>>1)+(amp>>2)`, and later sets use `amp`. With fewer than four sets, the full level is never reached.
- R9: `amp_code` carries the current set's level during sink and recharge pulses and is zero at every other time. Without ramp, that level is `cfg_amp`.
- R10: `sink_en` and `src_en` are never high together, and both are low during dead zones, gaps, the therapy delay and idle.
- R11: A `trig` pulse while `busy` is high has no effect on the running profile and does not restart it afterward.
- R12: The phase state only advances on cycles with `tick` high, so every phase lasts its tick count regardless of the tick spacing.
- R13: A reset asserted in the middle of a therapy returns the engine to idle, and it stays idle afterward without a new trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Stimulation tick enable, one cycle per tick |
| trig | input | 1 | Start strobe, honoured only while idle |
| cfg_amp | input | 8 | Target amplitude code |
| cfg_pw | input | 8 | Sink pulse width in ticks |
| cfg_dz0 | input | 8 | Dead zone after each pulse, in ticks |
| cfg_delta | input | 8 | Recharge trim: bit 7 sign, bits 6:0 magnitude |
| cfg_dz1 | input | 8 | Gap between periods, in DZ1_UNIT ticks |
| cfg_m | input | 8 | Periods per set |
| cfg_dz2 | input | 8 | Gap between sets, in DZ2_UNIT ticks |
| cfg_thp | input | 8 | Therapy delay, in THP_UNIT ticks |
| cfg_n | input | 8 | Sets per master pulse |
| cfg_dz3 | input | 8 | Gap between master pulses, in DZ3_UNIT ticks |
| cfg_p | input | 8 | Master pulses per therapy |
| cfg_ramp | input | 1 | Amplitude ramp enable |
| sink_en | output | 1 | Sink pulse active |
| src_en | output | 1 | Recharge (source) pulse active |
| amp_code | output | 8 | Amplitude code for the active pulse |
| busy | output | 1 | Therapy in progress |

## Verification
`busy` and the therapy-delay phase appear one clock after the edge that samples `trig`. The output for every later phase is visible in the cycle after the tick-enabled edge that closed the previous phase. The bench drives inputs and samples outputs at falling edges. It walks an expected profile built from the requirements one tick slot at a time, and each slot holds exactly the tick spacing in clocks. Every slot is checked, including the non-tick clocks inside it, so a phase that is late or early by even one clock is caught. The idle check falls on the first falling edge after the final tick.

// File: rtl/stim_pkg.sv
package stim_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_DELAY,
        PH_SINK,
        PH_DEAD_A,
        PH_SOURCE,
        PH_DEAD_B,
        PH_GAP_PER,
        PH_GAP_SET,
        PH_GAP_MST
    } phase_e;

    typedef struct packed {
        logic [7:0] amp;
        logic [7:0] pw;
        logic [7:0] dz0;
        logic [7:0] delta;
        logic [7:0] dz1;
        logic [7:0] m;
        logic [7:0] dz2;
        logic [7:0] thp;
        logic [7:0] n;
        logic [7:0] dz3;
        logic [7:0] p;
        logic       ramp;
    } stim_cfg_t;

    localparam int RECH_W = 11;

    // Recharge width: four sink widths with signed trim, floored at one tick.
    function automatic logic [RECH_W-1:0] recharge_ticks(input logic [7:0] pw,
                                                         input logic [7:0] delta);
        logic [RECH_W:0] base;
        logic [RECH_W:0] mag;
        base = {1'b0, ({3'b000, (pw == 8'd0) ? 8'd1 : pw} << 2)};
        mag  = {5'd0, delta[6:0]};
        if (!delta[7])
            return RECH_W'(base + mag);
        else if (base > mag)
            return RECH_W'(base - mag);
        else
            return RECH_W'(1);
    endfunction

    // Ramp level chosen by the set index inside the master pulse.
    function automatic logic [7:0] ramp_level(input logic [7:0] amp,
                                              input logic [7:0] set_idx,
                                              input logic       en);
        if (!en || set_idx >= 8'd3)
            return amp;
        case (set_idx[1:0])
            2'd0:    return amp >> 2;
            2'd1:    return amp >> 1;
            default: return (amp >> 1) + (amp >> 2);
        endcase
    endfunction

endpackage

// File: rtl/stim_rep_ctr.sv
module stim_rep_ctr (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       inc,
    input  logic [7:0] limit,
    output logic [7:0] count,
    output logic       last
);
    logic [7:0] lim_eff;

    assign lim_eff = (limit == 8'd0) ? 8'd1 : limit;
    assign last    = (count == lim_eff - 8'd1);

    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= 8'd0;
        else if (inc)
            count <= count + 8'd1;
    end

    // R5/R6/R7: a repetition counter never reaches its own limit
    a_r5_count_in_range: assert property (@(posedge clk) disable iff (rst)
        count < lim_eff);

    a_r7_no_wrap_on_last: assert property (@(posedge clk) disable iff (rst)
        (inc && last) |-> clr);

endmodule

// File: rtl/stim_phase_len.sv
module stim_phase_len
    import stim_pkg::*;
#(
    parameter int LW       = 29,
    parameter int DZ1_UNIT = 8,
    parameter int DZ2_UNIT = 4096,
    parameter int DZ3_UNIT = 2097152,
    parameter int THP_UNIT = 4096
) (
    input  phase_e         ph,
    input  stim_cfg_t      cfg,
    output logic [LW-1:0]  len
);
    function automatic logic [LW-1:0] scaled(input logic [7:0] f, input int unit);
        if (f == 8'd0)
            return LW'(1);
        return LW'(f) * LW'(unit);
    endfunction

    always_comb begin
        case (ph)
            PH_DELAY:   len = scaled(cfg.thp, THP_UNIT);
            PH_SINK:    len = scaled(cfg.pw, 1);
            PH_DEAD_A,
            PH_DEAD_B:  len = scaled(cfg.dz0, 1);
            PH_SOURCE:  len = LW'(recharge_ticks(cfg.pw, cfg.delta));
            PH_GAP_PER: len = scaled(cfg.dz1, DZ1_UNIT);
            PH_GAP_SET: len = scaled(cfg.dz2, DZ2_UNIT);
            PH_GAP_MST: len = scaled(cfg.dz3, DZ3_UNIT);
            default:    len = LW'(1);
        endcase
    end

    // R3/R4: every phase lasts at least one tick
    always_comb a_r4_len_nonzero: assert (len != '0);

endmodule

// File: rtl/stim_seq.sv
module stim_seq
    import stim_pkg::*;
#(
    parameter int DZ1_UNIT = 8,
    parameter int DZ2_UNIT = 4096,
    parameter int DZ3_UNIT = 2097152,
    parameter int THP_UNIT = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       trig,
    input  logic [7:0] cfg_amp,
    input  logic [7:0] cfg_pw,
    input  logic [7:0] cfg_dz0,
    input  logic [7:0] cfg_delta,
    input  logic [7:0] cfg_dz1,
    input  logic [7:0] cfg_m,
    input  logic [7:0] cfg_dz2,
    input  logic [7:0] cfg_thp,
    input  logic [7:0] cfg_n,
    input  logic [7:0] cfg_dz3,
    input  logic [7:0] cfg_p,
    input  logic       cfg_ramp,
    output logic       sink_en,
    output logic       src_en,
    output logic [7:0] amp_code,
    output logic       busy
);
    localparam int MAXU_A = (DZ1_UNIT > DZ2_UNIT) ? DZ1_UNIT : DZ2_UNIT;
    localparam int MAXU_B = (DZ3_UNIT > THP_UNIT) ? DZ3_UNIT : THP_UNIT;
    localparam int MAXU   = (MAXU_A > MAXU_B) ? MAXU_A : MAXU_B;
    localparam longint LONGEST_A = 64'd255 * 64'(MAXU);
    localparam longint LONGEST   = (LONGEST_A > 64'd2048) ? LONGEST_A : 64'd2048;
    localparam int LW     = $clog2(LONGEST + 1);
    localparam int LEVELS = 3;

    stim_cfg_t      cfg;
    phase_e         ph, ph_nxt, ph_load;
    logic [LW-1:0]  rem, load_len;
    logic           start, phase_done, period_end;
    logic [7:0]     lvl_limit [LEVELS];
    logic [7:0]     lvl_count [LEVELS];
    logic           lvl_last  [LEVELS];
    logic           lvl_inc   [LEVELS];
    logic           lvl_clr   [LEVELS];

    assign cfg = '{amp: cfg_amp, pw: cfg_pw, dz0: cfg_dz0, delta: cfg_delta,
                   dz1: cfg_dz1, m: cfg_m, dz2: cfg_dz2, thp: cfg_thp,
                   n: cfg_n, dz3: cfg_dz3, p: cfg_p, ramp: cfg_ramp};

    assign start      = (ph == PH_IDLE) && trig;
    assign phase_done = (ph != PH_IDLE) && tick && (rem == LW'(1));
    assign period_end = phase_done && (ph == PH_DEAD_B);

    assign lvl_limit[0] = cfg.m;
    assign lvl_limit[1] = cfg.n;
    assign lvl_limit[2] = cfg.p;

    // Level k advances when all inner levels are on their last count.
    generate
        for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
            logic inner_full;
            if (k == 0) begin : g_inner0
                assign inner_full = period_end;
            end else begin : g_innerk
                assign inner_full = g_lvl[k-1].inner_full && lvl_last[k-1];
            end
            assign lvl_inc[k] = inner_full && !lvl_last[k];
            assign lvl_clr[k] = start || (inner_full && lvl_last[k]);

            stim_rep_ctr u_ctr (
                .clk   (clk),
                .rst   (rst),
                .clr   (lvl_clr[k]),
                .inc   (lvl_inc[k]),
                .limit (lvl_limit[k]),
                .count (lvl_count[k]),
                .last  (lvl_last[k])
            );
        end
    endgenerate

    always_comb begin
        case (ph)
            PH_DELAY:   ph_nxt = PH_SINK;
            PH_SINK:    ph_nxt = PH_DEAD_A;
            PH_DEAD_A:  ph_nxt = PH_SOURCE;
            PH_SOURCE:  ph_nxt = PH_DEAD_B;
            PH_DEAD_B: begin
                if (!lvl_last[0])      ph_nxt = PH_GAP_PER;
                else if (!lvl_last[1]) ph_nxt = PH_GAP_SET;
                else if (!lvl_last[2]) ph_nxt = PH_GAP_MST;
                else                   ph_nxt = PH_IDLE;
            end
            PH_GAP_PER,
            PH_GAP_SET,
            PH_GAP_MST: ph_nxt = PH_SINK;
            default:    ph_nxt = PH_IDLE;
        endcase
    end

    assign ph_load = (ph == PH_IDLE) ? PH_DELAY : ph_nxt;

    stim_phase_len #(
        .LW(LW), .DZ1_UNIT(DZ1_UNIT), .DZ2_UNIT(DZ2_UNIT),
        .DZ3_UNIT(DZ3_UNIT), .THP_UNIT(THP_UNIT)
    ) u_len (
        .ph  (ph_load),
        .cfg (cfg),
        .len (load_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            rem <= '0;
        end else if (start) begin
            ph  <= PH_DELAY;
            rem <= load_len;
        end else if (phase_done) begin
            ph  <= ph_nxt;
            rem <= load_len;
        end else if (ph != PH_IDLE && tick) begin
            rem <= rem - LW'(1);
        end
    end

    assign sink_en  = (ph == PH_SINK);
    assign src_en   = (ph == PH_SOURCE);
    assign busy     = (ph != PH_IDLE);
    assign amp_code = (sink_en || src_en) ? ramp_level(cfg.amp, lvl_count[1], cfg.ramp) : 8'd0;

    // R10: pulses are exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(sink_en && src_en));

    // R9/R10: nothing is driven while idle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sink_en && !src_en && amp_code == 8'd0));

    // R3: a dead zone always follows the sink pulse
    a_r3_dead_after_sink: assert property (@(posedge clk) disable iff (rst)
        $fell(sink_en) |-> !src_en);

    // R2: a trigger while idle starts the therapy
    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && trig) |=> busy);

    // R11: a trigger cannot end a running therapy early
    a_r11_trig_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && trig && !tick) |=> busy);

    // R12: without a tick the phase holds
    a_r12_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(ph));

    // R1/R13: reset always lands in idle
    a_r13_reset_idle: assert property (@(posedge clk)
        rst |=> !busy);

endmodule

// File: tb/stim_seq_test.sv
`timescale 1ns/1ps
module stim_seq_test;
    localparam int U1 = 2, U2 = 3, U3 = 5, UT = 2;

    logic clk = 1'b0, rst = 1'b1, tick = 1'b0, trig = 1'b0;
    logic [7:0] amp, pw, dz0, delta, dz1, m, dz2, thp, n, dz3, p;
    logic ramp;
    logic sink_en, src_en, busy;
    logic [7:0] amp_code;

    int checks = 0, fails = 0;
    int div = 1, slot = 0, poke_at = -1;

    always #2 clk = ~clk;

    stim_seq #(.DZ1_UNIT(U1), .DZ2_UNIT(U2), .DZ3_UNIT(U3), .THP_UNIT(UT)) uut (
        .clk(clk), .rst(rst), .tick(tick), .trig(trig),
        .cfg_amp(amp), .cfg_pw(pw), .cfg_dz0(dz0), .cfg_delta(delta),
        .cfg_dz1(dz1), .cfg_m(m), .cfg_dz2(dz2), .cfg_thp(thp),
        .cfg_n(n), .cfg_dz3(dz3), .cfg_p(p), .cfg_ramp(ramp),
        .sink_en(sink_en), .src_en(src_en), .amp_code(amp_code), .busy(busy)
    );

    function automatic logic [10:0] outs();
        return {sink_en, src_en, amp_code, busy};
    endfunction

    task automatic chk(input string req, input logic [10:0] got, input logic [10:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h (sink,src,amp,busy)", req, got, exp);
        end
    endtask

    task automatic expect_seg(input string req, input logic s, input logic r,
                              input logic [7:0] a, input int len);
        logic [10:0] exp, bad_val;
        bit bad = 0;
        exp = {s, r, a, 1'b1};
        bad_val = exp;
        for (int k = 0; k < len; k++) begin
            for (int d = 0; d < div; d++) begin
                if (!bad && outs() !== exp) begin
                    bad = 1;
                    bad_val = outs();
                end
                trig = (slot == poke_at);
                tick = (d == div - 1);
                slot++;
                @(negedge clk);
            end
        end
        chk(req, bad ? bad_val : exp, exp);
    endtask

    function automatic int nz(input logic [7:0] f, input int unit);
        return (f == 0) ? 1 : int'(f) * unit;
    endfunction

    function automatic logic [7:0] level(input int set_idx);
        if (!ramp || set_idx >= 3) return amp;
        if (set_idx == 0) return amp / 4;
        if (set_idx == 1) return amp / 2;
        return 8'(amp / 2 + amp / 4);
    endfunction

    task automatic start();
        @(negedge clk);
        trig = 1'b1;
        tick = 1'b0;
        @(negedge clk);
        trig = 1'b0;
        slot = 0;
    endtask

    task automatic run_profile(input string tag);
        int pwl, rech, mm, nn, pp;
        logic [7:0] lv;
        pwl = nz(pw, 1);
        rech = delta[7] ? 4 * pwl - int'(delta[6:0]) : 4 * pwl + int'(delta[6:0]);
        if (rech < 1) rech = 1;
        mm = nz(m, 1); nn = nz(n, 1); pp = nz(p, 1);
        start();
        expect_seg({tag, " R2 delay"}, 0, 0, 0, nz(thp, UT));
        for (int mi = 0; mi < pp; mi++)
            for (int si = 0; si < nn; si++) begin
                lv = level(si);
                for (int pi = 0; pi < mm; pi++) begin
                    expect_seg({tag, " R3 R9 R8 sink"}, 1, 0, lv, pwl);
                    expect_seg({tag, " R3 R10 dead"}, 0, 0, 0, nz(dz0, 1));
                    expect_seg({tag, " R4 R9 recharge"}, 0, 1, lv, rech);
                    expect_seg({tag, " R3 R10 dead"}, 0, 0, 0, nz(dz0, 1));
                    if (pi < mm - 1)      expect_seg({tag, " R5 gap"}, 0, 0, 0, nz(dz1, U1));
                    else if (si < nn - 1) expect_seg({tag, " R6 gap"}, 0, 0, 0, nz(dz2, U2));
                    else if (mi < pp - 1) expect_seg({tag, " R7 gap"}, 0, 0, 0, nz(dz3, U3));
                end
            end
        trig = 1'b0;
        tick = 1'b0;
        chk({tag, " R7 end idle"}, outs(), 11'd0);
        repeat (3) @(negedge clk);
        chk({tag, " R11 no restart"}, outs(), 11'd0);
    endtask

    task automatic set_cfg(input logic [7:0] a_amp, a_pw, a_dz0, a_delta, a_dz1, a_m,
                           a_dz2, a_thp, a_n, a_dz3, a_p, input logic a_ramp);
        amp = a_amp; pw = a_pw; dz0 = a_dz0; delta = a_delta; dz1 = a_dz1; m = a_m;
        dz2 = a_dz2; thp = a_thp; n = a_n; dz3 = a_dz3; p = a_p; ramp = a_ramp;
    endtask

    initial begin
        #800000;
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        set_cfg(100, 2, 1, 0, 1, 2, 1, 1, 2, 1, 2, 0);
        repeat (3) @(negedge clk);
        chk("R1 reset state", outs(), 11'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", outs(), 11'd0);

        // Basic nesting, one tick per clock
        run_profile("basic");
        // Longer gaps and positive trim
        set_cfg(77, 3, 2, 8'h05, 2, 3, 2, 2, 2, 1, 1, 0);
        run_profile("trimplus");
        // Negative trim
        set_cfg(9, 2, 1, 8'h83, 1, 1, 1, 1, 1, 1, 2, 0);
        run_profile("trimminus");
        // Negative trim saturating at one tick
        set_cfg(250, 1, 3, 8'h8F, 1, 2, 1, 1, 1, 1, 1, 0);
        run_profile("trimfloor");
        // Ramp across five sets, two master pulses
        set_cfg(203, 1, 1, 0, 1, 1, 1, 1, 5, 2, 2, 1);
        run_profile("ramp5");
        // Ramp with fewer than four sets never reaches full level
        set_cfg(255, 1, 1, 0, 1, 2, 1, 1, 2, 1, 1, 1);
        run_profile("ramp2");
        // All zero fields count as one
        set_cfg(42, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        run_profile("zeros");
        // Slow tick plus a trigger poke mid-run (R12, R11)
        div = 3;
        poke_at = 20;
        set_cfg(60, 2, 1, 8'h02, 1, 2, 1, 1, 2, 1, 1, 1);
        run_profile("slowtick");
        div = 1;
        poke_at = -1;

        // Reset in the middle of a therapy
        set_cfg(90, 4, 2, 0, 3, 4, 3, 1, 3, 2, 2, 0);
        start();
        tick = 1'b1;
        repeat (7) @(negedge clk);
        chk("R13 still busy before reset", {1'b0, 1'b0, 8'd0, busy}, 11'd1);
        rst = 1'b1;
        @(negedge clk);
        chk("R13 idle after mid-run reset", outs(), 11'd0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk("R13 stays idle", outs(), 11'd0);
        tick = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule